// File: doc/BRIEF.md
# Mixed-Length Instruction Fetch Aligner

This block sits between an instruction fetch port and the decoder of a core whose instructions are either one 16-bit parcel or two. It takes 32-bit little-endian fetch words, each made of a lower and an upper 16-bit half. From them it builds complete instructions in program order. A short instruction is handed over zero-extended. A long instruction that begins in the upper half of one fetch word is assembled from that half and the lower half of the following word.

Fetch words arrive on a valid/ready handshake. The block publishes the word-aligned address of the word it wants next, and raises a request flag whenever its next parcel is not already buffered. Each finished instruction is offered with its own address and its sequential successor address, which is 2 or 4 bytes on depending on its length. It is held until the consumer takes it. A flush with a redirect address drops all partial and unconsumed state and restarts assembly at the new address.

Top module: `insn_aligner`

## Requirements
- R1: Reset leaves no instruction on offer and insn_o at zero. It raises more_o and word_ready_o and sets fetch_addr_o to the reset address, which is 0 by default.
- R2: A 16-bit parcel is short (compressed) when its bits 1:0 differ from 2'b11; it starts a 32-bit instruction when they are 2'b11.
- R3: At a PC whose bit 1 is 0, a short lower half is offered as {16'h0, word[15:0]} with next_pc_o = PC+2. The word's upper half is kept, and more_o stays 0 while this instruction is offered. The following instruction then comes from that kept half without another fetch handshake.
- R4: At a PC whose bit 1 is 0, a long instruction is offered as the whole word, with next_pc_o = PC+4. While it is offered, more_o is 1 and fetch_addr_o is the address of the following word.
- R5: At a PC whose bit 1 is 1, a short upper half is offered as {16'h0, word[31:16]}, with next_pc_o = PC+2.
- R6: At a PC whose bit 1 is 1, a long instruction is offered as {next_word[15:0], word[31:16]}, with next_pc_o = PC+4. While the first half waits, fetch_addr_o points at the following word. While the result is offered, more_o is 0.
- R7: While an instruction is offered and insn_ready_i is 0, insn_o, insn_pc_o and insn_valid_o hold, and word_ready_o is 0.
- R8: A cycle with flush_i at 1 accepts no fetch word (word_ready_o is 0) and leaves no instruction on offer in the next cycle. Assembly resumes at redirect_pc_i with bit 0 ignored.
- R9: Instructions are offered in program order: each insn_pc_o equals the previous next_pc_o unless a flush came in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Discard all state and restart at redirect_pc_i |
| redirect_pc_i | input | AW | Restart address for a flush (bit 0 ignored) |
| word_valid_i | input | 1 | Fetch word on word_i is valid |
| word_i | input | FW | Fetch word from address fetch_addr_o, little-endian |
| word_ready_o | output | 1 | Block accepts the fetch word this cycle |
| more_o | output | 1 | Next parcel is not buffered; another fetch word is needed |
| fetch_addr_o | output | AW | Word-aligned address of the fetch word wanted next |
| insn_valid_o | output | 1 | A complete instruction is on offer |
| insn_o | output | FW | Assembled instruction, short ones zero-extended |
| insn_pc_o | output | AW | Address of the offered instruction |
| next_pc_o | output | AW | Sequential successor address (plus 2 or plus 4) |
| insn_ready_i | input | 1 | Consumer takes the offered instruction this cycle |

## Verification
The assertions assume that word_i is always the memory word at the current fetch_addr_o. They also assume that the consumer's hold-stability contract only applies in cycles without a flush. The stimulus keeps to both. It drives word_i combinationally from a fixed memory image indexed by fetch_addr_o, and it lowers insn_ready_i in every flush cycle so that a take never coincides with a redirect. Redirect addresses are made odd on purpose, to show that bit 0 is dropped. The memory image mixes short and long parcels so that every alignment and length combination occurs.

// File: rtl/aln_pkg.sv
package aln_pkg;

    // Width of one instruction parcel
    localparam int unsigned PARCEL_W = 16;

    // Low-bit pattern that marks the first parcel of a long instruction
    localparam logic [1:0] LONG_TAG = 2'b11;

    // Address steps for short and long instructions, in bytes
    localparam int unsigned SHORT_BYTES = PARCEL_W / 8;
    localparam int unsigned LONG_BYTES  = 2 * SHORT_BYTES;

endpackage

// File: rtl/aln_parcel.sv
module aln_parcel
    import aln_pkg::*;
#(
    parameter int unsigned PW = PARCEL_W
) (
    input  logic [PW-1:0]   parcel_i,
    output logic            short_o,
    output logic [2*PW-1:0] wide_o
);

    // A parcel is short unless its two lowest bits are both set
    assign short_o = (parcel_i[1:0] != LONG_TAG);
    assign wide_o  = {{PW{1'b0}}, parcel_i};

endmodule

// File: rtl/aln_pc_step.sv
module aln_pc_step
    import aln_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic [AW-1:0] pc_i,
    input  logic          short_i,
    output logic [AW-1:0] npc_o
);

    localparam logic [AW-1:0] STEP_S = AW'(SHORT_BYTES);
    localparam logic [AW-1:0] STEP_L = AW'(LONG_BYTES);

    assign npc_o = pc_i + (short_i ? STEP_S : STEP_L);

endmodule

// File: rtl/insn_aligner.sv
module insn_aligner
    import aln_pkg::*;
#(
    parameter int unsigned   AW       = 32,
    parameter int unsigned   FW       = 2 * PARCEL_W,
    parameter logic [AW-1:0] RESET_PC = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_i,
    input  logic [AW-1:0] redirect_pc_i,
    input  logic          word_valid_i,
    input  logic [FW-1:0] word_i,
    output logic          word_ready_o,
    output logic          more_o,
    output logic [AW-1:0] fetch_addr_o,
    output logic          insn_valid_o,
    output logic [FW-1:0] insn_o,
    output logic [AW-1:0] insn_pc_o,
    output logic [AW-1:0] next_pc_o,
    input  logic          insn_ready_i
);

    localparam int unsigned HW = FW / 2;
    localparam int unsigned WA = AW - 2;

    typedef struct packed {
        logic [AW-1:0] pc;        // start address of next instruction to build
        logic [HW-1:0] hold;      // buffered upper half of the last word
        logic          hold_vld;
        logic [FW-1:0] stash;     // first half of a straddling instruction
        logic          pend;
        logic [FW-1:0] out_insn;
        logic [AW-1:0] out_pc;
        logic [AW-1:0] out_npc;
        logic          out_vld;
    } state_t;

    state_t st_d, st_q;

    // Parcel classification for both word halves and the buffered half
    logic [1:0]    half_short;
    logic [FW-1:0] half_wide [2];
    logic          hold_short;
    logic [FW-1:0] hold_wide;

    for (genvar g = 0; g < 2; g++) begin : g_half
        aln_parcel #(.PW(HW)) u_half (
            .parcel_i (word_i[g*HW +: HW]),
            .short_o  (half_short[g]),
            .wide_o   (half_wide[g])
        );
    end

    aln_parcel #(.PW(HW)) u_hold (
        .parcel_i (st_q.hold),
        .short_o  (hold_short),
        .wide_o   (hold_wide)
    );

    // Handshake and source selection
    logic can_adv, take_word;
    assign can_adv      = !st_q.out_vld || insn_ready_i;
    assign more_o       = !st_q.hold_vld;
    assign word_ready_o = more_o && can_adv && !flush_i;
    assign take_word    = word_ready_o && word_valid_i;

    // Upper-half parcel: from the buffer if present, else from the new word
    logic          off_short;
    logic [FW-1:0] off_wide;
    assign off_short = st_q.hold_vld ? hold_short : half_short[1];
    assign off_wide  = st_q.hold_vld ? hold_wide  : half_wide[1];

    // Length of whatever instruction would be emitted this cycle
    logic emit_short;
    assign emit_short = st_q.pend ? 1'b0 :
                        (st_q.hold_vld || st_q.pc[1]) ? off_short : half_short[0];

    logic [AW-1:0] npc;
    aln_pc_step #(.AW(AW)) u_step (
        .pc_i    (st_q.pc),
        .short_i (emit_short),
        .npc_o   (npc)
    );

    logic          emit;
    logic [FW-1:0] emit_insn;

    always_comb begin
        st_d      = st_q;
        emit      = 1'b0;
        emit_insn = '0;

        if (st_q.out_vld && insn_ready_i) begin
            st_d.out_vld = 1'b0;
        end

        if (flush_i) begin
            st_d.pc       = redirect_pc_i & ~{{(AW-1){1'b0}}, 1'b1};
            st_d.hold_vld = 1'b0;
            st_d.pend     = 1'b0;
            st_d.stash    = '0;
            st_d.out_vld  = 1'b0;
        end else if (can_adv) begin
            if (st_q.pend) begin
                if (take_word) begin
                    emit          = 1'b1;
                    emit_insn     = st_q.stash | {word_i[HW-1:0], {HW{1'b0}}};
                    st_d.pend     = 1'b0;
                    st_d.stash    = '0;
                    st_d.hold     = word_i[FW-1:HW];
                    st_d.hold_vld = 1'b1;
                end
            end else if (st_q.hold_vld || (take_word && st_q.pc[1])) begin
                st_d.hold_vld = 1'b0;
                if (off_short) begin
                    emit      = 1'b1;
                    emit_insn = off_wide;
                end else begin
                    st_d.pend  = 1'b1;
                    st_d.stash = off_wide;
                end
            end else if (take_word) begin
                emit = 1'b1;
                if (half_short[0]) begin
                    emit_insn     = half_wide[0];
                    st_d.hold     = word_i[FW-1:HW];
                    st_d.hold_vld = 1'b1;
                end else begin
                    emit_insn = word_i;
                end
            end

            if (emit) begin
                st_d.out_insn = emit_insn;
                st_d.out_pc   = st_q.pc;
                st_d.out_npc  = npc;
                st_d.out_vld  = 1'b1;
                st_d.pc       = npc;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.pc       <= RESET_PC;
        end else begin
            st_q <= st_d;
        end
    end

    logic [WA-1:0] word_idx;
    assign word_idx     = st_q.pc[AW-1:2] + {{(WA-1){1'b0}}, st_q.pend};
    assign fetch_addr_o = {word_idx, 2'b00};

    assign insn_valid_o = st_q.out_vld;
    assign insn_o       = st_q.out_insn;
    assign insn_pc_o    = st_q.out_pc;
    assign next_pc_o    = st_q.out_npc;

    // Assertions
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid_o && !insn_ready_i && !flush_i) |=> (insn_valid_o && $stable(insn_o) && $stable(insn_pc_o))); // R7

    AST_NO_ACCEPT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid_o && !insn_ready_i) |-> !word_ready_o); // R7

    AST_STEP_BY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        insn_valid_o |-> (next_pc_o == insn_pc_o + ((insn_o[1:0] == LONG_TAG) ? AW'(LONG_BYTES) : AW'(SHORT_BYTES)))); // R2

    AST_SHORT_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid_o && insn_o[1:0] != LONG_TAG) |-> (insn_o[FW-1:HW] == '0)); // R3

    AST_MERGE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pend |-> (st_q.stash[FW-1:HW] == '0)); // R6

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !insn_valid_o); // R8

    AST_FLUSH_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |-> !word_ready_o); // R8

endmodule

// File: tb/tb_insn_aligner.sv
module tb_insn_aligner;

    localparam int AW = 32;
    localparam int FW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush_i = 1'b0;
    logic [AW-1:0] redirect_pc_i = '0;
    logic          word_valid_i = 1'b0;
    logic [FW-1:0] word_i;
    logic          word_ready_o, more_o, insn_valid_o;
    logic [AW-1:0] fetch_addr_o, insn_pc_o, next_pc_o;
    logic [FW-1:0] insn_o;
    logic          insn_ready_i = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    insn_aligner dut (
        .clk, .rst_n, .flush_i, .redirect_pc_i, .word_valid_i, .word_i,
        .word_ready_o, .more_o, .fetch_addr_o, .insn_valid_o, .insn_o,
        .insn_pc_o, .next_pc_o, .insn_ready_i
    );

    // Memory image: 512 halfwords, wrapping
    function automatic logic [15:0] mem_half(input logic [31:0] addr);
        logic [31:0] idx;
        logic [31:0] m;
        logic [15:0] h;
        idx = (addr >> 1) & 32'h1FF;
        m   = idx * 32'h9E3779B1 + 32'h5BD1;
        h   = m[27:12];
        if (idx % 3 == 0) h[1:0] = 2'b11;
        return h;
    endfunction

    assign word_i = {mem_half(fetch_addr_o + 32'd2), mem_half(fetch_addr_o)};

    int checks = 0;
    int fails  = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    initial begin
        logic [31:0] model_pc;
        logic [31:0] last_npc;
        bit          have_last;
        bit          prev_hold;
        bit          prev_flush;
        logic [31:0] prev_insn;
        logic [31:0] prev_pc;
        int          idle;
        int          takes;

        model_pc = 32'h0; have_last = 0; prev_hold = 0; prev_flush = 0;
        prev_insn = '0; prev_pc = '0; idle = 0; takes = 0; last_npc = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1: reset state
        check(insn_valid_o == 1'b0, "R1 valid", {31'b0, insn_valid_o}, 32'h0);
        check(insn_o == '0, "R1 insn", insn_o, 32'h0);
        check(more_o == 1'b1, "R1 more", {31'b0, more_o}, 32'h1);
        check(word_ready_o == 1'b1, "R1 ready", {31'b0, word_ready_o}, 32'h1);
        check(fetch_addr_o == 32'h0, "R1 fetch_addr", fetch_addr_o, 32'h0);

        for (int cyc = 0; cyc < 6000; cyc++) begin
            @(negedge clk);

            // R7: offer held across a stall
            if (prev_hold) begin
                check(insn_valid_o == 1'b1, "R7 valid held", {31'b0, insn_valid_o}, 32'h1);
                check(insn_o == prev_insn, "R7 insn held", insn_o, prev_insn);
                check(insn_pc_o == prev_pc, "R7 pc held", insn_pc_o, prev_pc);
            end
            // R8: nothing on offer after a flush
            if (prev_flush)
                check(insn_valid_o == 1'b0, "R8 empty after flush", {31'b0, insn_valid_o}, 32'h0);

            flush_i       = (cyc % 353 == 170);
            redirect_pc_i = 32'h0000_0100 + 32'(cyc) * 32'd6 + 32'd1;
            insn_ready_i  = !flush_i && (cyc % 7 != 3) && (cyc % 11 != 5)
                            && !(cyc >= 1000 && cyc < 1012);
            word_valid_i  = (cyc % 5 != 2);
            #1;

            if (flush_i) begin
                check(word_ready_o == 1'b0, "R8 no accept in flush", {31'b0, word_ready_o}, 32'h0);
            end
            if (insn_valid_o && !insn_ready_i)
                check(word_ready_o == 1'b0, "R7 no accept while full", {31'b0, word_ready_o}, 32'h0);

            if (insn_valid_o) begin
                bit sh;
                bit exp_more;
                sh = (insn_o[1:0] != 2'b11);
                exp_more = !((sh && !insn_pc_o[1]) || (!sh && insn_pc_o[1]));
                check(more_o == exp_more, sh ? (insn_pc_o[1] ? "R5 more" : "R3 more") :
                                               (insn_pc_o[1] ? "R6 more" : "R4 more"),
                      {31'b0, more_o}, {31'b0, exp_more});
                if (more_o)
                    check(fetch_addr_o == (next_pc_o & ~32'h3), "R4/R6 fetch_addr",
                          fetch_addr_o, next_pc_o & ~32'h3);
            end

            if (insn_valid_o && insn_ready_i) begin
                logic [15:0] h0;
                logic [31:0] exp_insn;
                logic [31:0] exp_npc;
                string       tag;
                h0 = mem_half(model_pc);
                if (h0[1:0] != 2'b11) begin
                    exp_insn = {16'h0, h0};
                    exp_npc  = model_pc + 32'd2;
                    tag = model_pc[1] ? "R2/R5 short upper" : "R2/R3 short lower";
                end else begin
                    exp_insn = {mem_half(model_pc + 32'd2), h0};
                    exp_npc  = model_pc + 32'd4;
                    tag = model_pc[1] ? "R2/R6 straddling long" : "R2/R4 aligned long";
                end
                check(insn_o == exp_insn, tag, insn_o, exp_insn);
                check(insn_pc_o == model_pc, "R9 insn_pc", insn_pc_o, model_pc);
                check(next_pc_o == exp_npc, tag, next_pc_o, exp_npc);
                if (have_last)
                    check(insn_pc_o == last_npc, "R9 order", insn_pc_o, last_npc);
                last_npc  = next_pc_o;
                have_last = 1;
                model_pc  = exp_npc;
                takes++;
                idle = 0;
            end else begin
                idle++;
            end

            if (flush_i) begin
                model_pc  = redirect_pc_i & ~32'h1;
                have_last = 0;
            end

            prev_hold  = insn_valid_o && !insn_ready_i && !flush_i;
            prev_flush = flush_i;
            prev_insn  = insn_o;
            prev_pc    = insn_pc_o;

            if (idle > 200) begin
                check(1'b0, "watchdog R9 progress", 32'(idle), 32'd0);
                break;
            end
        end

        check(takes > 1000, "R9 throughput", 32'(takes), 32'd1000);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule